// File: doc/BRIEF.md
# Processor mode and stack state registers

This block keeps the architectural mode state of a small microcontroller core: a main and a process stack pointer, a two-bit control register (thread privilege and stack select), the number of the exception being serviced, and the five arithmetic condition flags. The core's mode (thread or handler) comes in as an input. From it and the control bits the block derives the stack pointer in use and the effective privilege level. It also assembles a 32-bit status word that combines the flags and the exception number.

Software reaches the registers through a special-register port. A 5-bit select code picks the register. Reads are combinational and writes take effect on the next clock edge. The exception controller loads the exception number on entry and on return. The ALU updates the flags through its own port. Software cannot change the exception number.

Top module: `sysstate_regs`

## Requirements
- R1: After reset the main stack pointer holds SP_RESET, and the process stack pointer, the control bits, the flags and the exception number are all zero. The block is therefore privileged and uses the main stack.
- R2: In thread mode the active stack pointer is the process one when control bit 1 is 1, and the main one otherwise.
- R3: In handler mode the main stack pointer is active even when control bit 1 is 1, which is the reserved encoding.
- R4: The privilege output is 1 in handler mode whatever control bit 0 holds. In thread mode it is the inverse of control bit 0.
- R5: When exc_enter or exc_return is high, exc_num is loaded into the exception-number field at the clock edge. Status bits [EXC_W-1:0] show this field in handler mode and read 0 in thread mode.
- R6: A software write to select code 0x05 (exception number) has no effect. A read of 0x05 returns the same value as status bits [EXC_W-1:0].
- R7: The flags sit at status bits 31 (N), 30 (Z), 29 (C), 28 (V) and 27 (Q). When flag_we is high, flag_in {N,Z,C,V,Q} (bit 4 down to bit 0) is loaded at the clock edge. The ALU load wins over a software flag write in the same cycle.
- R8: A software write to code 0x00 (flag view) loads sr_wdata[31:27] into the flags. A read of 0x00 returns the flags in bits 31:27 and zero in bits 26:0.
- R9: Code 0x08 selects the main stack pointer and 0x09 the process one. A write to either stores sr_wdata with bits 1:0 forced to zero.
- R10: Code 0x14 selects the control register in bits 1:0, and the other bits read 0. A write there takes effect only while the block is privileged. An unprivileged write is ignored.
- R11: Code 0x03 reads the full status word. Every other code reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| sr_sel | input | 5 | Special-register select code |
| sr_we | input | 1 | Special-register write strobe |
| sr_wdata | input | 32 | Special-register write data |
| sr_rdata | output | 32 | Special-register read data (combinational) |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| exc_num | input | EXC_W | Exception number to load on entry or return |
| flag_we | input | 1 | ALU flag update strobe |
| flag_in | input | 5 | New flags {N,Z,C,V,Q} |
| sp_active | output | 32 | Stack pointer currently in use |
| privileged | output | 1 | Effective privilege (1 = privileged) |
| status_word | output | 32 | Flags in 31:27, exception number in low bits |

## Verification
The bench uses the defaults EXC_W = 9 and a non-zero, word-aligned SP_RESET, so the reset value of the main stack pointer can be told apart from a cleared register. With the full 9-bit exception number, random values reach the high bits of the field, including 511, and show that nothing spills toward the flag bits. Random mode changes, together with control writes made in both modes, reach the reserved handler-plus-select case and the case where an unprivileged write is refused. Only a pass through handler mode can leave the unprivileged state.

// File: rtl/sysstate_regs.sv
module sysstate_regs #(
  parameter int          EXC_W    = 9,
  parameter logic [31:0] SP_RESET = 32'h2000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             handler_mode,
  input  logic [4:0]       sr_sel,
  input  logic             sr_we,
  input  logic [31:0]      sr_wdata,
  output logic [31:0]      sr_rdata,
  input  logic             exc_enter,
  input  logic             exc_return,
  input  logic [EXC_W-1:0] exc_num,
  input  logic             flag_we,
  input  logic [4:0]       flag_in,
  output logic [31:0]      sp_active,
  output logic             privileged,
  output logic [31:0]      status_word
);
  localparam logic [4:0] SEL_FLAGS  = 5'h00;
  localparam logic [4:0] SEL_STATUS = 5'h03;
  localparam logic [4:0] SEL_EXCNUM = 5'h05;
  localparam logic [4:0] SEL_MSP    = 5'h08;
  localparam logic [4:0] SEL_PSP    = 5'h09;
  localparam logic [4:0] SEL_CTRL   = 5'h14;
  localparam int         PAD_W      = 32 - EXC_W;

  logic [31:0]      msp_q, psp_q;
  logic [1:0]       ctrl_q;
  logic [4:0]       flags_q;
  logic [EXC_W-1:0] exc_q;
  logic [31:0]      exc_view;
  logic             wr_flags, wr_msp, wr_psp, wr_ctrl;

  assign wr_flags = sr_we && sr_sel == SEL_FLAGS;
  assign wr_msp   = sr_we && sr_sel == SEL_MSP;
  assign wr_psp   = sr_we && sr_sel == SEL_PSP;
  assign wr_ctrl  = sr_we && sr_sel == SEL_CTRL && privileged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msp_q   <= {SP_RESET[31:2], 2'b00};
      psp_q   <= '0;
      ctrl_q  <= '0;
      flags_q <= '0;
      exc_q   <= '0;
    end else begin
      if (wr_msp)  msp_q  <= {sr_wdata[31:2], 2'b00};
      if (wr_psp)  psp_q  <= {sr_wdata[31:2], 2'b00};
      if (wr_ctrl) ctrl_q <= sr_wdata[1:0];
      if (flag_we)       flags_q <= flag_in;
      else if (wr_flags) flags_q <= sr_wdata[31:27];
      if (exc_enter || exc_return) exc_q <= exc_num;
    end
  end

  assign privileged  = handler_mode || !ctrl_q[0];
  assign sp_active   = (!handler_mode && ctrl_q[1]) ? psp_q : msp_q;
  assign exc_view    = handler_mode ? {{PAD_W{1'b0}}, exc_q} : 32'd0;
  assign status_word = {flags_q, 27'd0} | exc_view;

  always_comb begin
    case (sr_sel)
      SEL_FLAGS:  sr_rdata = {flags_q, 27'd0};
      SEL_STATUS: sr_rdata = status_word;
      SEL_EXCNUM: sr_rdata = exc_view;
      SEL_MSP:    sr_rdata = msp_q;
      SEL_PSP:    sr_rdata = psp_q;
      SEL_CTRL:   sr_rdata = {30'd0, ctrl_q};
      default:    sr_rdata = 32'd0;
    endcase
  end

  // R3
  handler_uses_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> sp_active == msp_q);

  // R4
  handler_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> privileged);

  // R5
  thread_excnum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !handler_mode |-> status_word[EXC_W-1:0] == '0);

  // R6
  excnum_sw_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && sr_sel == SEL_EXCNUM && !exc_enter && !exc_return) |=> $stable(exc_q));

  // R7
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> status_word[31:27] == $past(flag_in));

  // R10
  unpriv_ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!handler_mode && ctrl_q[0]) |=> $stable(ctrl_q));

  // R9
  sp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_active[1:0] == 2'b00);
endmodule

// File: tb/tb_sysstate_regs.sv
module tb_sysstate_regs;
  localparam int          EXC_W    = 9;
  localparam logic [31:0] SP_RESET = 32'h2000_1000;

  logic clk = 0, rst_n = 0;
  logic handler_mode = 0, sr_we = 0, exc_enter = 0, exc_return = 0, flag_we = 0;
  logic [4:0] sr_sel = 0, flag_in = 0;
  logic [31:0] sr_wdata = 0;
  logic [EXC_W-1:0] exc_num = 0;
  logic [31:0] sr_rdata, sp_active, status_word;
  logic privileged;

  int checks = 0, errors = 0;
  logic [31:0] m_msp, m_psp;
  logic [1:0] m_ctrl;
  logic [4:0] m_flags;
  logic [EXC_W-1:0] m_exc;

  always #5 clk = ~clk;

  sysstate_regs #(.EXC_W(EXC_W), .SP_RESET(SP_RESET)) dut (.*);

  function automatic logic exp_priv();
    return handler_mode || !m_ctrl[0];
  endfunction
  function automatic logic [31:0] exp_sp();
    return (!handler_mode && m_ctrl[1]) ? m_psp : m_msp;
  endfunction
  function automatic logic [31:0] exp_status();
    logic [31:0] w;
    w = {m_flags, 27'd0};
    if (handler_mode) w[EXC_W-1:0] = m_exc;
    return w;
  endfunction
  function automatic logic [31:0] exp_read(input logic [4:0] s);
    case (s)
      5'h00: return {m_flags, 27'd0};
      5'h03: return exp_status();
      5'h05: return handler_mode ? 32'(m_exc) : 32'd0;
      5'h08: return m_msp;
      5'h09: return m_psp;
      5'h14: return {30'd0, m_ctrl};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(sp_active == exp_sp(), handler_mode ? "R3 sp in handler" : "R2 sp in thread", sp_active, exp_sp());
    chk(privileged == exp_priv(), "R4 privilege", 32'(privileged), 32'(exp_priv()));
    chk(status_word == exp_status(), "R5/R7 status word", status_word, exp_status());
    chk(sr_rdata == exp_read(sr_sel), "R11 read data", sr_rdata, exp_read(sr_sel));
  endtask

  task automatic model_edge();
    logic pr;
    pr = exp_priv();
    if (sr_we && sr_sel == 5'h08) m_msp = {sr_wdata[31:2], 2'b00};
    if (sr_we && sr_sel == 5'h09) m_psp = {sr_wdata[31:2], 2'b00};
    if (sr_we && sr_sel == 5'h14 && pr) m_ctrl = sr_wdata[1:0];
    if (flag_we) m_flags = flag_in;
    else if (sr_we && sr_sel == 5'h00) m_flags = sr_wdata[31:27];
    if (exc_enter || exc_return) m_exc = exc_num;
  endtask

  task automatic step(input logic hm, input logic we, input logic [4:0] sel, input logic [31:0] wd,
                      input logic ee, input logic er, input logic [EXC_W-1:0] en,
                      input logic fw, input logic [4:0] fi);
    @(negedge clk);
    handler_mode = hm; sr_we = we; sr_sel = sel; sr_wdata = wd;
    exc_enter = ee; exc_return = er; exc_num = en; flag_we = fw; flag_in = fi;
    #1 check_all();
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(input logic hm, input logic [4:0] sel);
    step(hm, 0, sel, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_msp = {SP_RESET[31:2], 2'b00}; m_psp = 0; m_ctrl = 0; m_flags = 0; m_exc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #1;
    chk(sp_active == SP_RESET, "R1 reset sp", sp_active, SP_RESET);
    chk(privileged == 1'b1, "R1 reset privilege", 32'(privileged), 32'd1);
    chk(status_word == 32'd0, "R1 reset status", status_word, 32'd0);
    // R9 unaligned writes
    step(0, 1, 5'h09, 32'h1234_5677, 0, 0, 0, 0, 0);
    step(0, 1, 5'h08, 32'h3000_00FF, 0, 0, 0, 0, 0);
    idle(0, 5'h09);
    chk(sr_rdata == 32'h1234_5674, "R9 psp aligned", sr_rdata, 32'h1234_5674);
    idle(0, 5'h08);
    chk(sr_rdata == 32'h3000_00FC, "R9 msp aligned", sr_rdata, 32'h3000_00FC);
    // R2 select process stack in thread
    step(0, 1, 5'h14, 32'h2, 0, 0, 0, 0, 0);
    idle(0, 5'h14);
    chk(sp_active == 32'h1234_5674, "R2 psp active", sp_active, 32'h1234_5674);
    // R3 reserved: select bit set in handler mode
    step(1, 0, 5'h00, 0, 1, 0, 9'd511, 0, 0);
    idle(1, 5'h05);
    chk(sp_active == 32'h3000_00FC, "R3 msp in handler", sp_active, 32'h3000_00FC);
    chk(status_word == 32'd511, "R5 exc number 511", status_word, 32'd511);
    // R6 software write to exception number ignored
    step(1, 1, 5'h05, 32'h0000_0007, 0, 0, 0, 0, 0);
    idle(1, 5'h05);
    chk(sr_rdata == 32'd511, "R6 excnum write ignored", sr_rdata, 32'd511);
    // R10 drop privilege, then unprivileged write ignored
    step(0, 1, 5'h14, 32'h1, 0, 1, 0, 0, 0);
    step(0, 1, 5'h14, 32'h0, 0, 0, 0, 0, 0);
    idle(0, 5'h14);
    chk(sr_rdata == 32'h1, "R10 unpriv ctrl write ignored", sr_rdata, 32'h1);
    chk(privileged == 1'b0, "R4 thread unprivileged", 32'(privileged), 32'd0);
    idle(1, 5'h14);
    chk(privileged == 1'b1, "R4 handler privileged", 32'(privileged), 32'd1);
    // R7 ALU beats software flag write
    step(1, 1, 5'h00, 32'hF800_0000, 0, 0, 0, 1, 5'b01010);
    idle(1, 5'h00);
    chk(sr_rdata == 32'h5000_0000, "R7 ALU wins flags", sr_rdata, 32'h5000_0000);
    // R8 software flag write
    step(1, 1, 5'h00, 32'hA7FF_FFFF, 0, 0, 0, 0, 0);
    idle(1, 5'h00);
    chk(sr_rdata == 32'hA000_0000, "R8 flag view", sr_rdata, 32'hA000_0000);
    // R11 unknown code
    step(1, 1, 5'h1F, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    idle(1, 5'h1F);
    chk(sr_rdata == 32'd0, "R11 unknown code reads zero", sr_rdata, 32'd0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] s;
      case ($urandom % 8)
        0: s = 5'h00; 1: s = 5'h03; 2: s = 5'h05; 3: s = 5'h08;
        4: s = 5'h09; 5: s = 5'h14; 6: s = 5'h14; default: s = 5'($urandom);
      endcase
      step(1'($urandom), ($urandom % 3) == 0, s, $urandom,
           ($urandom % 6) == 0, ($urandom % 8) == 0, EXC_W'($urandom),
           ($urandom % 4) == 0, 5'($urandom));
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule